// File: doc/BRIEF.md
# Display window flush sequencer

This block moves one rectangular window of RGB565 pixels into a small LCD controller that uses the standard display command set. A request gives a clip rectangle whose start corners are inclusive and whose end corners are exclusive. The block then emits the column-window command, the row-window command and the memory-write command, and after them the pixel stream. Pixels come from a valid/ready source that is either 16-bit RGB565 or 32-bit XRGB, and an option swaps the two bytes of each pixel. Every byte leaves through one valid/ready byte lane, with a flag that marks a byte as command (0) or parameter/pixel data (1). A downstream serializer turns this lane into the wire format.

The block also owns the panel reset line. After the block leaves reset, it holds the panel in reset for 20 ms and releases it. It then waits 120 ms before it accepts any work. Both delays are counted in clock cycles derived from a clock-frequency parameter. Two more requests are served. A blank request paints the whole panel with zero pixels and takes nothing from the pixel source. A power check sends the power-mode read command, takes one returned byte, and reports whether the panel is already on.

Back-pressure rules: once `out_valid` is high, `out_byte` and `out_is_data` stay fixed and `out_valid` stays high until a cycle with `out_ready` high. Only that cycle transfers the byte. A pixel transfers in a cycle where both `pix_valid` and `pix_ready` are high. The block pulls at most one pixel ahead of the byte lane.

Top module: `lcd_flush_seq`

## Requirements
- R1: After `rst_n` is released, `panel_rst_n` stays low for CLK_HZ/1000*RST_LOW_MS cycles, then goes high and stays high. `init_done` rises CLK_HZ/1000*RST_WAIT_MS cycles later. Before `init_done` is high, `out_valid` stays low and every request is ignored.
- R2: A flush emits, in this order: command 0x2A, four data bytes, command 0x2B, four data bytes, command 0x2C, and then the pixel bytes. Commands carry `out_is_data`=0. Parameters and pixels carry `out_is_data`=1.
- R3: Each window command carries the 16-bit start and the 16-bit inclusive end as start high, start low, end high, end low. The end is the exclusive bound minus one, and both of its bytes come from that one decremented value. For example, an exclusive bound of 256 gives 0x00, 0xFF.
- R4: After 0x2C the block emits exactly 2·(x1−x0)·(y1−y0) data bytes and pulls exactly (x1−x0)·(y1−y0) pixels.
- R5: With `src_xrgb`=0 the pixel is `pix_data[15:0]`, sent high byte first.
- R6: With `src_xrgb`=1 the pixel is reduced to {`pix_data[23:19]`, `pix_data[15:10]`, `pix_data[7:3]`} before it is sent.
- R7: With `swap_bytes`=1 each pixel is sent low byte first.
- R8: A blank request uses the window 0..PANEL_W−1 by 0..PANEL_H−1 and sends 2·PANEL_W·PANEL_H zero bytes. It never raises `pix_ready`.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_byte` and `out_is_data` hold their values into the next cycle.
- R10: `flush_ready` is low from acceptance until completion. `flush_done` pulses for exactly one cycle after the last byte transfers. Requests that arrive while the block is busy are dropped.
- R11: A flush with x1≤x0 or y1≤y0 emits no byte and still pulses `flush_done`.
- R12: A power check emits command 0x0A and waits for `rd_valid`. It then sets `display_on` to 1 only when the returned byte, with bits 0, 1 and 7 cleared, equals 0x1C. It pulses `pwr_check_done` for one cycle, and `display_on` holds until the next check.
- R13: When requests coincide in an idle cycle, the flush is served first, then blank, then the power check. The losers are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| panel_rst_n | output | 1 | Reset line to the panel, active low |
| init_done | output | 1 | Panel power-up wait finished |
| flush_req | input | 1 | Start a window flush (sampled when `flush_ready`) |
| blank_req | input | 1 | Start a full-panel blank |
| win_x0 | input | 16 | Inclusive first column |
| win_x1 | input | 16 | Exclusive column bound |
| win_y0 | input | 16 | Inclusive first row |
| win_y1 | input | 16 | Exclusive row bound |
| src_xrgb | input | 1 | Source pixels are 32-bit XRGB |
| swap_bytes | input | 1 | Send each pixel low byte first |
| flush_ready | output | 1 | Idle and able to accept a request |
| flush_done | output | 1 | One-cycle pulse at the end of a flush or blank |
| pix_valid | input | 1 | Source pixel valid |
| pix_data | input | 32 | Source pixel word |
| pix_ready | output | 1 | Block takes a pixel this cycle |
| out_valid | output | 1 | Byte lane valid |
| out_ready | input | 1 | Byte lane accepted |
| out_byte | output | 8 | Byte value |
| out_is_data | output | 1 | 1 = parameter/pixel, 0 = command |
| pwr_check_req | input | 1 | Start a power-mode check |
| rd_valid | input | 1 | Returned read byte valid |
| rd_byte | input | 8 | Returned read byte |
| pwr_check_done | output | 1 | One-cycle pulse when the check result is ready |
| display_on | output | 1 | Result of the last power check |

## Verification
Flushes are tried with a small mid-panel window and a free-flowing lane, then with XRGB pixels under lane and source stalls. These show whether the byte order and the format reduction survive back-pressure. Windows that end exactly at 256, and windows that cross 256, separate a correct inclusive end from one whose high byte is taken before the decrement. A zero-width window, a request made while busy, and requests made together test the empty-window, drop and priority rules. The power check gets returned bytes that differ only in reserved bits or only in meaningful bits, which shows whether the mask is applied correctly.

// File: rtl/lcd_flush_pkg.sv
package lcd_flush_pkg;
  localparam int COORD_W = 16;
  localparam int HDR_LAST = 10;

  localparam logic [7:0] OP_COL_WIN  = 8'h2A;
  localparam logic [7:0] OP_ROW_WIN  = 8'h2B;
  localparam logic [7:0] OP_MEM_WR   = 8'h2C;
  localparam logic [7:0] OP_PWR_READ = 8'h0A;

  localparam logic [7:0] PWR_RESERVED = 8'h83;
  localparam logic [7:0] PWR_ON_VALUE = 8'h1C;

  typedef struct packed {
    logic       is_data;
    logic [7:0] val;
  } lane_byte_t;

  typedef enum logic [3:0] {
    S_IDLE, S_HDR, S_PGET, S_PB0, S_PB1, S_DONE, S_QCMD, S_QWAIT, S_QDONE
  } seq_state_t;
endpackage

// File: rtl/lcd_reset_timer.sv
module lcd_reset_timer #(
  parameter int CLK_HZ      = 100_000_000,
  parameter int RST_LOW_MS  = 20,
  parameter int RST_WAIT_MS = 120
) (
  input  logic clk,
  input  logic rst_n,
  output logic panel_rst_n,
  output logic init_done
);
  localparam int LOW_CYC  = CLK_HZ / 1000 * RST_LOW_MS;
  localparam int WAIT_CYC = CLK_HZ / 1000 * RST_WAIT_MS;
  localparam int MAX_CYC  = (LOW_CYC > WAIT_CYC) ? LOW_CYC : WAIT_CYC;
  localparam int CW       = $clog2(MAX_CYC + 1);

  typedef enum logic [1:0] {T_LOW, T_WAIT, T_RUN} tphase_t;
  tphase_t        phase;
  logic [CW-1:0]  cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= T_LOW;
      cnt   <= '0;
    end else begin
      case (phase)
        T_LOW: begin
          if (cnt == CW'(LOW_CYC - 1)) begin
            phase <= T_WAIT;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        T_WAIT: begin
          if (cnt == CW'(WAIT_CYC - 1)) begin
            phase <= T_RUN;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: phase <= T_RUN;
      endcase
    end
  end

  assign panel_rst_n = (phase != T_LOW);
  assign init_done   = (phase == T_RUN);

  // R1: once the panel leaves reset it is never pulled low again
  a_r1_release_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    panel_rst_n |=> panel_rst_n);
endmodule

// File: rtl/lcd_hdr_mux.sv
module lcd_hdr_mux
  import lcd_flush_pkg::*;
(
  input  logic [3:0]         idx,
  input  logic [COORD_W-1:0] col_lo,
  input  logic [COORD_W-1:0] col_hi,
  input  logic [COORD_W-1:0] row_lo,
  input  logic [COORD_W-1:0] row_hi,
  output lane_byte_t         hb
);
  always_comb begin
    case (idx)
      4'd0:    hb = '{is_data: 1'b0, val: OP_COL_WIN};
      4'd1:    hb = '{is_data: 1'b1, val: col_lo[15:8]};
      4'd2:    hb = '{is_data: 1'b1, val: col_lo[7:0]};
      4'd3:    hb = '{is_data: 1'b1, val: col_hi[15:8]};
      4'd4:    hb = '{is_data: 1'b1, val: col_hi[7:0]};
      4'd5:    hb = '{is_data: 1'b0, val: OP_ROW_WIN};
      4'd6:    hb = '{is_data: 1'b1, val: row_lo[15:8]};
      4'd7:    hb = '{is_data: 1'b1, val: row_lo[7:0]};
      4'd8:    hb = '{is_data: 1'b1, val: row_hi[15:8]};
      4'd9:    hb = '{is_data: 1'b1, val: row_hi[7:0]};
      default: hb = '{is_data: 1'b0, val: OP_MEM_WR};
    endcase
  end
endmodule

// File: rtl/lcd_pixel_fmt.sv
module lcd_pixel_fmt #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] word,
  input  logic              xrgb,
  input  logic              swap,
  input  logic              zero,
  output logic [7:0]        first_b,
  output logic [7:0]        second_b
);
  logic [15:0] rgb;

  always_comb begin
    if (zero)      rgb = 16'h0000;
    else if (xrgb) rgb = {word[23:19], word[15:10], word[7:3]};
    else           rgb = word[15:0];
    first_b  = swap ? rgb[7:0]  : rgb[15:8];
    second_b = swap ? rgb[15:8] : rgb[7:0];
  end
endmodule

// File: rtl/lcd_flush_seq.sv
module lcd_flush_seq
  import lcd_flush_pkg::*;
#(
  parameter int CLK_HZ      = 100_000_000,
  parameter int RST_LOW_MS  = 20,
  parameter int RST_WAIT_MS = 120,
  parameter int PANEL_W     = 240,
  parameter int PANEL_H     = 320,
  parameter int PIX_W       = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             panel_rst_n,
  output logic             init_done,
  input  logic             flush_req,
  input  logic             blank_req,
  input  logic [15:0]      win_x0,
  input  logic [15:0]      win_x1,
  input  logic [15:0]      win_y0,
  input  logic [15:0]      win_y1,
  input  logic             src_xrgb,
  input  logic             swap_bytes,
  output logic             flush_ready,
  output logic             flush_done,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  output logic             pix_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_byte,
  output logic             out_is_data,
  input  logic             pwr_check_req,
  input  logic             rd_valid,
  input  logic [7:0]       rd_byte,
  output logic             pwr_check_done,
  output logic             display_on
);
  localparam logic [COORD_W-1:0] PW_LAST = COORD_W'(PANEL_W - 1);
  localparam logic [COORD_W-1:0] PH_LAST = COORD_W'(PANEL_H - 1);

  seq_state_t          state;
  logic [3:0]          hdr_idx;
  logic [COORD_W-1:0]  col_lo, col_hi, row_lo, row_hi;
  logic [COORD_W-1:0]  col_cnt, row_cnt;
  logic                blank_mode, fmt_xrgb, fmt_swap;
  logic [7:0]          pb0, pb1;
  lane_byte_t          hdr_b;
  logic [7:0]          cv_first, cv_second;
  logic                hs, win_empty;

  lcd_reset_timer #(
    .CLK_HZ(CLK_HZ), .RST_LOW_MS(RST_LOW_MS), .RST_WAIT_MS(RST_WAIT_MS)
  ) u_rst (
    .clk(clk), .rst_n(rst_n), .panel_rst_n(panel_rst_n), .init_done(init_done)
  );

  lcd_hdr_mux u_hdr (
    .idx(hdr_idx), .col_lo(col_lo), .col_hi(col_hi),
    .row_lo(row_lo), .row_hi(row_hi), .hb(hdr_b)
  );

  lcd_pixel_fmt #(.WORD_W(PIX_W)) u_fmt (
    .word(pix_data), .xrgb(fmt_xrgb), .swap(fmt_swap), .zero(blank_mode),
    .first_b(cv_first), .second_b(cv_second)
  );

  assign hs        = out_valid && out_ready;
  assign win_empty = (win_x1 <= win_x0) || (win_y1 <= win_y0);

  always_comb begin
    out_valid   = 1'b0;
    out_byte    = 8'h00;
    out_is_data = 1'b0;
    pix_ready   = 1'b0;
    case (state)
      S_HDR:  begin out_valid = 1'b1; out_byte = hdr_b.val; out_is_data = hdr_b.is_data; end
      S_PGET: pix_ready = !blank_mode;
      S_PB0:  begin out_valid = 1'b1; out_byte = pb0; out_is_data = 1'b1; end
      S_PB1:  begin out_valid = 1'b1; out_byte = pb1; out_is_data = 1'b1; end
      S_QCMD: begin out_valid = 1'b1; out_byte = OP_PWR_READ; out_is_data = 1'b0; end
      default: ;
    endcase
  end

  assign flush_ready    = init_done && (state == S_IDLE);
  assign flush_done     = (state == S_DONE);
  assign pwr_check_done = (state == S_QDONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      hdr_idx    <= '0;
      col_lo     <= '0;
      col_hi     <= '0;
      row_lo     <= '0;
      row_hi     <= '0;
      col_cnt    <= '0;
      row_cnt    <= '0;
      blank_mode <= 1'b0;
      fmt_xrgb   <= 1'b0;
      fmt_swap   <= 1'b0;
      pb0        <= '0;
      pb1        <= '0;
      display_on <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (init_done) begin
            if (flush_req) begin
              if (win_empty) begin
                state <= S_DONE;
              end else begin
                col_lo     <= win_x0;
                col_hi     <= win_x1 - 1'b1;
                row_lo     <= win_y0;
                row_hi     <= win_y1 - 1'b1;
                blank_mode <= 1'b0;
                fmt_xrgb   <= src_xrgb;
                fmt_swap   <= swap_bytes;
                hdr_idx    <= '0;
                state      <= S_HDR;
              end
            end else if (blank_req) begin
              col_lo     <= '0;
              col_hi     <= PW_LAST;
              row_lo     <= '0;
              row_hi     <= PH_LAST;
              blank_mode <= 1'b1;
              fmt_xrgb   <= 1'b0;
              fmt_swap   <= 1'b0;
              hdr_idx    <= '0;
              state      <= S_HDR;
            end else if (pwr_check_req) begin
              state <= S_QCMD;
            end
          end
        end
        S_HDR: begin
          if (hs) begin
            if (hdr_idx == 4'(HDR_LAST)) begin
              col_cnt <= '0;
              row_cnt <= '0;
              state   <= S_PGET;
            end else begin
              hdr_idx <= hdr_idx + 1'b1;
            end
          end
        end
        S_PGET: begin
          if (blank_mode || pix_valid) begin
            pb0   <= cv_first;
            pb1   <= cv_second;
            state <= S_PB0;
          end
        end
        S_PB0: if (hs) state <= S_PB1;
        S_PB1: begin
          if (hs) begin
            if (col_cnt == col_hi - col_lo) begin
              col_cnt <= '0;
              if (row_cnt == row_hi - row_lo) begin
                state <= S_DONE;
              end else begin
                row_cnt <= row_cnt + 1'b1;
                state   <= S_PGET;
              end
            end else begin
              col_cnt <= col_cnt + 1'b1;
              state   <= S_PGET;
            end
          end
        end
        S_DONE: state <= S_IDLE;
        S_QCMD: if (hs) state <= S_QWAIT;
        S_QWAIT: begin
          if (rd_valid) begin
            display_on <= ((rd_byte & ~PWR_RESERVED) == PWR_ON_VALUE);
            state      <= S_QDONE;
          end
        end
        S_QDONE: state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R9: a stalled byte is held unchanged
  a_r9_hold_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && $stable(out_is_data)));

  // R1: nothing leaves on the lane before the power-up wait ends
  a_r1_quiet_before_init: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !out_valid);

  // R2: command-flagged bytes are only the known opcodes
  a_r2_cmd_opcodes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_is_data) |->
      (out_byte == OP_COL_WIN || out_byte == OP_ROW_WIN ||
       out_byte == OP_MEM_WR  || out_byte == OP_PWR_READ));

  // R10: completion is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |=> !flush_done);

  // R12: check completion is a single-cycle pulse
  a_r12_check_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_check_done |=> !pwr_check_done);

  // R4: the source is never pulled while a byte is pending on the lane
  a_r4_one_pixel_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> !out_valid);
endmodule

// File: tb/lcd_flush_seq_bench.sv
module lcd_flush_seq_bench;
  localparam int CLK_HZ  = 50_000;
  localparam int PANEL_W = 8;
  localparam int PANEL_H = 4;
  localparam int LOW_CYC = CLK_HZ / 1000 * 20;
  localparam int WAIT_CYC = CLK_HZ / 1000 * 120;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic panel_rst_n, init_done, flush_ready, flush_done, pix_ready;
  logic out_valid, out_is_data, pwr_check_done, display_on;
  logic [7:0] out_byte;
  logic flush_req = 1'b0, blank_req = 1'b0, pwr_check_req = 1'b0;
  logic [15:0] win_x0 = '0, win_x1 = '0, win_y0 = '0, win_y1 = '0;
  logic src_xrgb = 1'b0, swap_bytes = 1'b0;
  logic pix_valid = 1'b0;
  logic [31:0] pix_data = '0;
  logic out_ready = 1'b0;
  logic rd_valid = 1'b0;
  logic [7:0] rd_byte = '0;

  always #5 clk = ~clk;

  lcd_flush_seq #(
    .CLK_HZ(CLK_HZ), .RST_LOW_MS(20), .RST_WAIT_MS(120),
    .PANEL_W(PANEL_W), .PANEL_H(PANEL_H), .PIX_W(32)
  ) u_lcd_flush_seq (
    .clk(clk), .rst_n(rst_n), .panel_rst_n(panel_rst_n), .init_done(init_done),
    .flush_req(flush_req), .blank_req(blank_req),
    .win_x0(win_x0), .win_x1(win_x1), .win_y0(win_y0), .win_y1(win_y1),
    .src_xrgb(src_xrgb), .swap_bytes(swap_bytes),
    .flush_ready(flush_ready), .flush_done(flush_done),
    .pix_valid(pix_valid), .pix_data(pix_data), .pix_ready(pix_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte),
    .out_is_data(out_is_data), .pwr_check_req(pwr_check_req),
    .rd_valid(rd_valid), .rd_byte(rd_byte),
    .pwr_check_done(pwr_check_done), .display_on(display_on)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int done_cnt = 0;
  int pdone_cnt = 0;
  bit throttle = 1'b0;
  bit blank_active = 1'b0;
  string cur_req = "R2";
  logic [8:0]  exp_q[$];
  logic [31:0] src_q[$];
  bit prev_stall = 1'b0;
  logic [8:0] prev_lane = '0;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference model: expected lane bytes and source pixels, compared every clock
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (prev_stall)
        check(out_valid && {out_is_data, out_byte} == prev_lane, "R9", "stalled byte changed",
              {out_valid, out_is_data, out_byte}, {1'b1, prev_lane});
      out_ready = throttle ? ((cyc % 3) != 0) : 1'b1;
      if (out_valid && out_ready) begin
        if (exp_q.size() == 0)
          check(1'b0, cur_req, "unexpected byte", {out_is_data, out_byte}, 0);
        else begin
          logic [8:0] e;
          e = exp_q.pop_front();
          check({out_is_data, out_byte} == e, cur_req, "lane byte", {out_is_data, out_byte}, e);
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_lane  = {out_is_data, out_byte};
      if (!init_done && out_valid) check(1'b0, "R1", "output before init", 1, 0);
      if (blank_active && pix_ready) check(1'b0, "R8", "pixel pulled during blank", 1, 0);
      if (src_q.size() > 0) pix_data = src_q[0];
      pix_valid = (src_q.size() > 0) && (!throttle || (cyc % 4) != 1);
      if (pix_valid && pix_ready) void'(src_q.pop_front());
      if (flush_done) done_cnt++;
      if (pwr_check_done) pdone_cnt++;
    end
  end

  task automatic push_hdr(logic [15:0] a0, logic [15:0] a1, logic [15:0] b0, logic [15:0] b1);
    exp_q.push_back({1'b0, 8'h2A});
    exp_q.push_back({1'b1, a0[15:8]}); exp_q.push_back({1'b1, a0[7:0]});
    exp_q.push_back({1'b1, a1[15:8]}); exp_q.push_back({1'b1, a1[7:0]});
    exp_q.push_back({1'b0, 8'h2B});
    exp_q.push_back({1'b1, b0[15:8]}); exp_q.push_back({1'b1, b0[7:0]});
    exp_q.push_back({1'b1, b1[15:8]}); exp_q.push_back({1'b1, b1[7:0]});
    exp_q.push_back({1'b0, 8'h2C});
  endtask

  task automatic start_flush(int x0, int x1, int y0, int y1, bit xr, bit sw, bit model, bit also_blank);
    if (model && x1 > x0 && y1 > y0) begin
      int n;
      push_hdr(16'(x0), 16'(x1 - 1), 16'(y0), 16'(y1 - 1));
      n = (x1 - x0) * (y1 - y0);
      for (int k = 0; k < n; k++) begin
        logic [31:0] p;
        logic [15:0] v;
        p = 32'(k) * 32'h9E3779B9 + 32'h00135724;
        src_q.push_back(p);
        v = xr ? {p[23:19], p[15:10], p[7:3]} : p[15:0];
        if (sw) begin
          exp_q.push_back({1'b1, v[7:0]}); exp_q.push_back({1'b1, v[15:8]});
        end else begin
          exp_q.push_back({1'b1, v[15:8]}); exp_q.push_back({1'b1, v[7:0]});
        end
      end
    end
    @(negedge clk);
    win_x0 = 16'(x0); win_x1 = 16'(x1); win_y0 = 16'(y0); win_y1 = 16'(y1);
    src_xrgb = xr; swap_bytes = sw; flush_req = 1'b1; blank_req = also_blank;
    @(negedge clk);
    flush_req = 1'b0; blank_req = 1'b0;
  endtask

  task automatic wait_done(string req, int d0);
    int t = 0;
    while (done_cnt == d0 && t < 20000) begin @(negedge clk); t++; end
    repeat (20) @(negedge clk);
    check(done_cnt == d0 + 1, req, "done pulse count", done_cnt - d0, 1);
    check(exp_q.size() == 0, req, "bytes left unsent", exp_q.size(), 0);
    check(src_q.size() == 0, req, "pixels left unpulled", src_q.size(), 0);
    check(flush_ready == 1'b1, "R10", "ready after done", flush_ready, 1);
  endtask

  task automatic pwr(logic [7:0] rv, bit exp_on, string req);
    int p0 = pdone_cnt;
    int t = 0;
    cur_req = req;
    exp_q.push_back({1'b0, 8'h0A});
    @(negedge clk); pwr_check_req = 1'b1;
    @(negedge clk); pwr_check_req = 1'b0;
    while (exp_q.size() != 0 && t < 1000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    rd_valid = 1'b1; rd_byte = rv;
    @(negedge clk); rd_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(pdone_cnt == p0 + 1, req, "check done pulses", pdone_cnt - p0, 1);
    check(display_on == exp_on, req, "display_on", display_on, exp_on);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int lowc = 0;
    int waitc = 0;
    int d0;
    repeat (3) @(negedge clk);
    check(panel_rst_n == 1'b0 && init_done == 1'b0 && flush_ready == 1'b0 && out_valid == 1'b0,
          "R1", "reset state", {panel_rst_n, init_done, flush_ready, out_valid}, 0);
    rst_n = 1'b1;
    while (panel_rst_n == 1'b0 && lowc < 100000) begin lowc++; @(negedge clk); end
    check(lowc == LOW_CYC, "R1", "reset low cycles", lowc, LOW_CYC);
    repeat (100) @(negedge clk);
    waitc = 100;
    // R1: a request during the power-up wait is dropped
    flush_req = 1'b1; win_x0 = 0; win_x1 = 2; win_y0 = 0; win_y1 = 1;
    @(negedge clk); flush_req = 1'b0; waitc++;
    while (init_done == 1'b0 && waitc < 100000) begin waitc++; @(negedge clk); end
    check(waitc == WAIT_CYC, "R1", "wait cycles", waitc, WAIT_CYC);
    repeat (30) @(negedge clk);
    check(done_cnt == 0 && exp_q.size() == 0, "R1", "early request ignored", done_cnt, 0);

    // R2 R3 R4 R5: small window, free lane
    cur_req = "R5"; d0 = done_cnt;
    start_flush(5, 8, 7, 9, 1'b0, 1'b0, 1'b1, 1'b0);
    check(flush_ready == 1'b0, "R10", "busy after accept", flush_ready, 0);
    wait_done("R4", d0);

    // R6 R9: XRGB under stalls
    cur_req = "R6"; throttle = 1'b1; d0 = done_cnt;
    start_flush(1, 3, 2, 4, 1'b1, 1'b0, 1'b1, 1'b0);
    wait_done("R6", d0);

    // R7 R3: swap, window crossing 256
    cur_req = "R7"; d0 = done_cnt;
    start_flush(254, 258, 0, 256, 1'b0, 1'b1, 1'b1, 1'b0);
    wait_done("R7", d0);
    throttle = 1'b0;

    // R3: exclusive bound exactly 256
    cur_req = "R3"; d0 = done_cnt;
    start_flush(250, 256, 10, 11, 1'b1, 1'b1, 1'b1, 1'b0);
    wait_done("R3", d0);

    // R11: empty windows
    cur_req = "R11"; d0 = done_cnt;
    start_flush(5, 5, 0, 3, 1'b0, 1'b0, 1'b1, 1'b0);
    wait_done("R11", d0);
    d0 = done_cnt;
    start_flush(0, 4, 9, 2, 1'b0, 1'b0, 1'b1, 1'b0);
    wait_done("R11", d0);

    // R10: request while busy is dropped
    cur_req = "R10"; d0 = done_cnt;
    start_flush(0, 3, 0, 3, 1'b0, 1'b0, 1'b1, 1'b0);
    repeat (4) @(negedge clk);
    start_flush(40, 60, 40, 60, 1'b1, 1'b1, 1'b0, 1'b1);
    wait_done("R10", d0);

    // R8: blank the full panel
    cur_req = "R8"; d0 = done_cnt; blank_active = 1'b1;
    push_hdr(16'd0, 16'(PANEL_W - 1), 16'd0, 16'(PANEL_H - 1));
    for (int k = 0; k < 2 * PANEL_W * PANEL_H; k++) exp_q.push_back({1'b1, 8'h00});
    @(negedge clk); blank_req = 1'b1;
    @(negedge clk); blank_req = 1'b0;
    wait_done("R8", d0);
    blank_active = 1'b0;

    // R13: flush and blank together, flush wins
    cur_req = "R13"; d0 = done_cnt;
    start_flush(3, 5, 1, 2, 1'b0, 1'b0, 1'b1, 1'b1);
    wait_done("R13", d0);

    // R12: power-mode check with masked reserved bits
    pwr(8'h9C, 1'b1, "R12");
    pwr(8'h3C, 1'b0, "R12");
    pwr(8'h1F, 1'b1, "R12");
    pwr(8'h0C, 1'b0, "R12");
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R12", "lane idle after check", exp_q.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule